// File: doc/BRIEF.md
# Streaming Serial Snapshot Transmitter

This block is a transmit-only serial master. It pushes a snapshot of up to sixteen signed 24-bit measurement samples to an external SPI-style receiver over three lines: an active-low select, a data line and a serial clock. A single-cycle start strobe freezes the whole sample bank and an 8-bit configuration byte. The block then widens each sample to 32 bits by sign extension and shifts the words out most significant bit first.

The configuration byte selects four things: the serial clock divisor (system clock divided by 2 or by 4), the package size (32-bit or 8-bit), an optional idle gap of seven serial-clock periods between packages, and the word set. The word set is either the full sixteen-word sequence or a short seven-word sequence whose last slot repeats the neutral-current sample. Bank slot k holds the sample sent in position k of the full sequence, and slot 7 is the neutral current. A one-cycle done pulse marks the end of each burst.

Top module: `snap_stream_tx`

## Requirements
- R1: When a burst starts, the block captures `samples` (slot k at bits [24k+23:24k]). In the full set it sends slots 0 to 15 in that order, each sign-extended to 32 bits and shifted MSB first.
- R2: When `cfg[4:3]` is 01, a burst sends seven words: slots 0 to 5, then slot 7 (the neutral current). Codes 10 and 11 behave exactly like 00.
- R3: `cfg[0]` sets the serial clock period: 2 system clocks when 0, 4 when 1. A burst lasts words*32 periods, plus any gap periods.
- R4: Each bit period starts with a falling serial-clock edge, where the data changes, and the clock is high in its second half. Data never changes at any other time while select is low.
- R5: When `cfg[2]` is 1, select goes high for exactly seven serial-clock periods after every package except the last. A package is 32 bits when `cfg[1]` is 0 and 8 bits when it is 1.
- R6: When `cfg[2]` is 0, select stays low for the whole burst and `cfg[1]` has no effect on the bit stream.
- R7: After reset and whenever no burst is running, select, data and serial clock are all high and `done_o` is low.
- R8: A start strobe during a burst is ignored, and a change of `cfg` during a burst has no effect on it. The configuration is captured only when a burst is launched.
- R9: `done_o` is high for exactly one system clock. It appears D+1 cycles after the clock edge that accepts the start, where D is the burst duration in system clocks.
- R10: While `en` is low, start strobes are ignored and any running burst is abandoned, which returns the lines to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable |
| start | input | 1 | Start-of-burst strobe |
| cfg | input | 8 | Configuration: [0] divisor, [1] 8-bit packages, [2] gaps, [4:3] word set |
| samples | input | 384 | Sixteen signed 24-bit samples, slot k at [24k+23:24k] |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial data, idles high |
| sel_n_o | output | 1 | Active-low select |
| done_o | output | 1 | One-cycle end-of-burst pulse |

## Verification
The main function is driven with a table of configuration bytes that covers both divisors, both package sizes with and without gaps, and all four word-set codes. Each entry uses its own pseudo-random sample bank, and the banks mix positive and negative values. Comparing the captured stream bit for bit separates sign extension and word order (full against reduced). Burst length and the count of select releases separate the divisor, the gap and package-size handling, and codes 10 and 11 from 01. Further runs send a second start and a new configuration in the middle of a burst, try a start with the port disabled, and check the reset state.

// File: rtl/snap_pkg.sv
package snap_pkg;
  localparam int SMP_W        = 24;
  localparam int WRD_W        = 32;
  localparam int N_SLOTS      = 16;
  localparam int SHORT_WORDS  = 7;
  localparam int SHORT_LAST   = 6;
  localparam int NEUTRAL_SLOT = 7;
  localparam int IDX_W        = $clog2(N_SLOTS);

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_GAP} tx_state_e;

  function automatic logic [WRD_W-1:0] widen(input logic [SMP_W-1:0] v);
    return {{(WRD_W-SMP_W){v[SMP_W-1]}}, v};
  endfunction

  function automatic logic short_set(input logic [1:0] code);
    return code == 2'b01;
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic short_mode, input logic [IDX_W-1:0] pos);
    if (short_mode && pos == IDX_W'(SHORT_LAST)) return IDX_W'(NEUTRAL_SLOT);
    return pos;
  endfunction

  function automatic logic [IDX_W-1:0] last_pos(input logic [1:0] code);
    return short_set(code) ? IDX_W'(SHORT_WORDS - 1) : IDX_W'(N_SLOTS - 1);
  endfunction

  function automatic logic [1:0] half_len(input logic slow);
    return slow ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/snap_bit_timer.sv
module snap_bit_timer #(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PH_W-1:0] half,
  output logic            slot_end,
  output logic            clk_hi
);
  logic [PH_W-1:0] phase;
  logic [PH_W:0]   period;

  assign period   = {half, 1'b0};
  assign slot_end = run && ({1'b0, phase} == period - 1'b1);
  assign clk_hi   = phase >= half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phase <= '0;
    else if (!run || slot_end)  phase <= '0;
    else                        phase <= phase + 1'b1;
  end
endmodule

// File: rtl/snap_seq.sv
module snap_seq
  import snap_pkg::*;
#(
  parameter int GAP_SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             launch,
  input  logic             slot_end,
  input  logic             pkg8,
  input  logic             gap_en,
  input  logic [IDX_W-1:0] last_idx,
  output tx_state_e        state,
  output logic [IDX_W-1:0] word_idx,
  output logic             shift_step,
  output logic             load_next,
  output logic             finish
);
  localparam int BIT_W = $clog2(WRD_W);
  localparam int GAP_W = $clog2(GAP_SLOTS + 1);

  logic [BIT_W-1:0] bit_idx;
  logic [GAP_W-1:0] gap_cnt;
  logic word_end, pkg_end, in_shift;

  always_comb begin
    in_shift   = state == ST_SHIFT;
    word_end   = bit_idx == BIT_W'(WRD_W - 1);
    pkg_end    = pkg8 ? (bit_idx[2:0] == 3'd7) : word_end;
    finish     = in_shift && slot_end && word_end && (word_idx == last_idx);
    shift_step = in_shift && slot_end && !finish;
    load_next  = shift_step && word_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bit_idx <= '0; word_idx <= '0; gap_cnt <= '0;
    end else if (!en) begin
      state <= ST_IDLE; bit_idx <= '0; word_idx <= '0; gap_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          state <= ST_SHIFT; bit_idx <= '0; word_idx <= '0; gap_cnt <= '0;
        end
        ST_SHIFT: if (finish) begin
          state <= ST_IDLE;
        end else if (shift_step) begin
          bit_idx <= bit_idx + 1'b1;
          if (word_end) word_idx <= word_idx + 1'b1;
          if (gap_en && pkg_end) begin
            state <= ST_GAP; gap_cnt <= '0;
          end
        end
        ST_GAP: if (slot_end) begin
          if (gap_cnt == GAP_W'(GAP_SLOTS - 1)) state <= ST_SHIFT;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/snap_stream_tx.sv
module snap_stream_tx
  import snap_pkg::*;
#(
  parameter int NUM_WORDS = N_SLOTS,
  parameter int SAMPLE_W  = SMP_W,
  parameter int GAP_SLOTS = 7,
  parameter int CFG_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          en,
  input  logic                          start,
  input  logic [CFG_W-1:0]              cfg,
  input  logic [NUM_WORDS*SAMPLE_W-1:0] samples,
  output logic                          sclk_o,
  output logic                          sdata_o,
  output logic                          sel_n_o,
  output logic                          done_o
);
  localparam int PH_W = 2;

  tx_state_e         state;
  logic [SAMPLE_W-1:0] bank_q [NUM_WORDS];
  logic [CFG_W-1:0]  cfg_q;
  logic [WRD_W-1:0]  shreg;
  logic [IDX_W-1:0]  word_idx, next_pos;
  logic              busy, burst_launch, slot_end, clk_hi;
  logic              shift_step, load_next, finish, done_q;

  assign busy         = state != ST_IDLE;
  assign burst_launch = en && start && !busy;
  assign next_pos     = word_idx + 1'b1;

  snap_bit_timer #(.PH_W(PH_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .half(half_len(cfg_q[0])), .slot_end(slot_end), .clk_hi(clk_hi)
  );

  snap_seq #(.GAP_SLOTS(GAP_SLOTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .launch(burst_launch),
    .slot_end(slot_end), .pkg8(cfg_q[1]), .gap_en(cfg_q[2]),
    .last_idx(last_pos(cfg_q[4:3])), .state(state), .word_idx(word_idx),
    .shift_step(shift_step), .load_next(load_next), .finish(finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) bank_q[i] <= '0;
      cfg_q <= '0;
      shreg <= '1;
    end else if (burst_launch) begin
      for (int i = 0; i < NUM_WORDS; i++) bank_q[i] <= samples[i*SAMPLE_W +: SAMPLE_W];
      cfg_q <= cfg;
      shreg <= widen(samples[SAMPLE_W-1:0]);
    end else if (load_next) begin
      shreg <= widen(bank_q[slot_of(short_set(cfg_q[4:3]), next_pos)]);
    end else if (shift_step) begin
      shreg <= {shreg[WRD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= finish;
  end

  assign sel_n_o = state != ST_SHIFT;
  assign sdata_o = sel_n_o ? 1'b1 : shreg[WRD_W-1];
  assign sclk_o  = sel_n_o ? 1'b1 : clk_hi;
  assign done_o  = done_q;
endmodule

// File: rtl/snap_stream_chk.sv
module snap_stream_chk #(
  parameter int CFG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             start,
  input logic             sclk_o,
  input logic             sdata_o,
  input logic             sel_n_o,
  input logic             done_o,
  input logic             busy,
  input logic             launch,
  input logic [CFG_W-1:0] cfg_q
);
  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sel_n_o && sdata_o && sclk_o)); // R7
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n_o && $past(!sel_n_o) && !$stable(sdata_o)) |-> $fell(sclk_o)); // R4
  AST_SELECT_OPENS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sel_n_o) |-> !sclk_o); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_DONE_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy) && !busy)); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q)); // R8
  AST_BUSY_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !launch); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy); // R10
endmodule

bind snap_stream_tx snap_stream_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .start(start), .sclk_o(sclk_o),
  .sdata_o(sdata_o), .sel_n_o(sel_n_o), .done_o(done_o), .busy(busy),
  .launch(burst_launch), .cfg_q(cfg_q)
);

// File: tb/snap_stream_tx_tb.sv
module snap_stream_tx_tb;
  localparam int NW = 16;
  localparam int SW = 24;
  localparam int NV = 11;
  localparam logic [7:0] VCFG [NV] = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h05, 8'h06,
                                       8'h07, 8'h08, 8'h0F, 8'h10, 8'h18};
  localparam int VSEED [NV] = '{3, 11, 29, 41, 57, 73, 89, 101, 131, 151, 173};
  localparam bit VMID  [NV] = '{0, 0, 1, 0, 0, 0, 1, 0, 1, 0, 0};

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, start = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic [NW*SW-1:0] samples = '0;
  logic sclk_o, sdata_o, sel_n_o, done_o;

  int tests = 0, fails = 0;
  bit cap_on = 0;
  logic cap [0:511];
  int cap_n = 0, sel_rises = 0, bad_edges = 0, sel_falls = 0;
  logic p_sclk = 1'b1, p_sdata = 1'b1, p_sel = 1'b1;

  snap_stream_tx u_dut (.clk(clk), .rst_n(rst_n), .en(en), .start(start), .cfg(cfg),
    .samples(samples), .sclk_o(sclk_o), .sdata_o(sdata_o), .sel_n_o(sel_n_o), .done_o(done_o));

  always #2 clk = ~clk;

  always @(posedge sclk_o) if (cap_on && !sel_n_o && cap_n < 512) begin
    cap[cap_n] = sdata_o; cap_n++;
  end
  always @(posedge sel_n_o) if (cap_on) sel_rises++;
  always @(negedge sel_n_o) sel_falls++;
  always @(negedge clk) begin
    if (cap_on && !sel_n_o && !p_sel && sdata_o !== p_sdata && !(p_sclk && !sclk_o))
      bad_edges++;
    p_sclk = sclk_o; p_sdata = sdata_o; p_sel = sel_n_o;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] smp(input int seed, input int k);
    logic [31:0] h;
    h = seed * 32'h9E3779B1 + k * 32'h7F4A7C15;
    h = h ^ (h >> 13);
    return h[27:4];
  endfunction

  task automatic run_burst(input logic [7:0] c, input int seed, input bit mid);
    int n, h, nwd, npk, dur, src, errs;
    logic [31:0] w;
    for (int k = 0; k < NW; k++) samples[k*SW +: SW] = smp(seed, k);
    h   = c[0] ? 2 : 1;
    nwd = (c[4:3] == 2'b01) ? 7 : 16;
    npk = nwd * (c[1] ? 4 : 1);
    dur = nwd * 32 * 2 * h + (c[2] ? (npk - 1) * 7 * 2 * h : 0);
    cap_n = 0; sel_rises = 0; bad_edges = 0; cap_on = 1;
    @(negedge clk); cfg = c; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int k = 0; k < NW; k++) samples[k*SW +: SW] = ~smp(seed, k);
    n = 1;
    while (!done_o && n < 20000) begin
      if (mid && n == 40) begin start = 1'b1; cfg = c ^ 8'h0F; end
      if (mid && n == 41) start = 1'b0;
      @(negedge clk); n++;
    end
    cap_on = 0;
    check("R3", "burst length", n, dur + 1);
    if (mid) check("R8", "length with mid-burst start and cfg change", n, dur + 1);
    check("R9", "done position", n, dur + 1);
    @(negedge clk);
    check("R9", "done width", done_o, 0);
    check("R1", "bits captured", cap_n, nwd * 32);
    errs = 0;
    for (int i = 0; i < nwd * 32 && i < cap_n; i++) begin
      src = (nwd == 7 && i / 32 == 6) ? 7 : i / 32;
      w = {{8{smp(seed, src)[23]}}, smp(seed, src)};
      if (cap[i] !== w[31 - i % 32]) errs++;
    end
    if (nwd == 7) check("R2", "short-set bit errors", errs, 0);
    else          check("R1", "full-set bit errors", errs, 0);
    if (c[2]) check("R5", "select releases", sel_rises, npk);
    else      check("R6", "select releases", sel_rises, 1);
    check("R4", "data changes off falling edge", bad_edges, 0);
    cfg = 8'h00;
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    check("R7", "reset sel", sel_n_o, 1);
    check("R7", "reset data", sdata_o, 1);
    check("R7", "reset sclk", sclk_o, 1);
    check("R7", "reset done", done_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    f0 = sel_falls;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    check("R10", "select activity while disabled", sel_falls - f0, 0);
    check("R10", "data line while disabled", sdata_o, 1);
    en = 1'b1;
    @(negedge clk);
    for (int v = 0; v < NV; v++) run_burst(VCFG[v], VSEED[v], VMID[v]);
    @(negedge clk); cfg = 8'h05; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check("R10", "abort releases select", sel_n_o, 1);
    check("R10", "abort clock idle", sclk_o, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule